// File: doc/BRIEF.md
# Digital Quadrature Carrier Mixer

This block sits after an interpolation chain and multiplies the interpolated I and Q sample streams by a digital carrier whose frequency is a fixed fraction of the output sample rate: none, one half, one quarter or one eighth. The carrier values are not produced by an oscillator or a stored table. They come from short repeating sequences of +1, 0, -1 and +/-1/sqrt(2), and an eight-step phase counter picks the value for each sample. The 1/sqrt(2) value is held as a fixed-point constant.

The block has two modes. In real mode each channel is multiplied by the same real carrier sequence on its own. In complex mode the cosine and sine products of I and Q are combined so that the output pair holds a single-sideband signal. Input samples may arrive as two's complement or as straight binary. Every product sum is kept at full precision, shifted down once, and then clamped to the 16-bit range. This guards the output against the roughly 3 dB gain that the complex combination can add.

A sample is accepted on each clock edge at which `valid_i` is high. The result is registered, so it appears one clock later together with `valid_o`.

Top module: `quad_mixer`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0, both DAC outputs are 0 and the carrier phase is step 0. The first accepted sample after reset uses step 0.
- R2: `valid_o` is `valid_i` delayed by one clock. The DAC outputs and the phase step change only on edges where `valid_i` is high. The phase step advances by one (modulo 8) for each accepted sample.
- R3: When `fmt_bin_i` is 1, the MSB of each input sample is inverted to form a two's complement value before mixing. When it is 0, samples are taken as two's complement.
- R4: `mod_sel_i` = 0 applies no modulation. In both modes the outputs equal the (format-converted) I and Q inputs.
- R5: `mod_sel_i` = 1 (half rate) multiplies successive samples by +1, -1, +1, -1, ... at steps 0,1,2,... In both modes channel A takes I and channel B takes Q.
- R6: `mod_sel_i` = 2 (quarter rate) in real mode multiplies both channels by the sequence 0, +1, 0, -1 at steps 0..3, repeating.
- R7: `mod_sel_i` = 3 (eighth rate) in real mode multiplies both channels by 0, s, 1, s, 0, -s, -1, -s at steps 0..7. Here s = 11585/16384 and unity is 16384/16384.
- R8: With `cplx_en_i` = 1, channel A = I*cos - Q*sin and channel B = I*sin + Q*cos. The cosine sequences by step are: none 1; half +1,-1; quarter 1,0,-1,0; eighth 1,s,0,-s,-1,-s,0,s. The sine sequences are: none 0; half 0; quarter 0,1,0,-1; eighth 0,s,1,s,0,-s,-1,-s.
- R9: Any result above 32767 gives 32767, and any result below -32768 gives -32768.
- R10: Each output is the full-precision sum of its products (coefficients scaled by 16384), arithmetically shifted right by 14 (floor), and then saturated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| i_data_i | input | 16 | In-phase sample |
| q_data_i | input | 16 | Quadrature sample |
| mod_sel_i | input | 2 | Carrier select: 0 none, 1 half, 2 quarter, 3 eighth |
| cplx_en_i | input | 1 | 1 selects complex single-sideband mode |
| fmt_bin_i | input | 1 | 1 selects straight binary input |
| valid_o | output | 1 | Output sample strobe |
| dac_a_o | output | 16 | Channel A result, two's complement |
| dac_b_o | output | 16 | Channel B result, two's complement |

## Verification
The bench drives -32768 through a negative carrier step. A design that negates without clamping would wrap that value back to -32768 instead of 32767. It drives full-scale equal I and Q in complex eighth-rate mode. There channel B reaches about 1.41 of full scale, and a design that truncates the sum would flip its sign. Gaps in the valid strobe and a mid-run reset expose a phase counter that free-runs or fails to return to step 0; either fault would misalign the quarter- and eighth-rate sequences. Negative odd products expose truncation toward zero where floor is required, and samples with the MSB set expose a swapped or missing format conversion.

// File: rtl/quad_mixer_pkg.sv
package quad_mixer_pkg;
  typedef enum logic [1:0] {
    MOD_NONE    = 2'd0,
    MOD_HALF    = 2'd1,
    MOD_QUARTER = 2'd2,
    MOD_EIGHTH  = 2'd3
  } mod_e;

  localparam int unsigned PHASE_W = 3;
endpackage

// File: rtl/qm_fmt.sv
module qm_fmt #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0]        raw_i,
  input  logic                     fmt_bin_i,
  output logic signed [DATA_W-1:0] smp_o
);
  // offset binary -> two's complement: flip MSB
  always_comb begin
    smp_o = raw_i;
    if (fmt_bin_i) smp_o[DATA_W-1] = ~raw_i[DATA_W-1];
  end
endmodule

// File: rtl/qm_carrier.sv
module qm_carrier
  import quad_mixer_pkg::*;
#(
  parameter int COEF_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     adv_i,
  input  mod_e                     mod_i,
  output logic [PHASE_W-1:0]       phase_o,
  output logic signed [COEF_W-1:0] cos_o,
  output logic signed [COEF_W-1:0] sin_o,
  output logic signed [COEF_W-1:0] real_o
);
  localparam int FRAC  = COEF_W - 2;
  localparam int ONE_I = 1 << FRAC;
  localparam int SQH_I = int'(real'(ONE_I) * 0.7071067811865476 - 0.5);
  localparam logic signed [COEF_W-1:0] ONE = COEF_W'(ONE_I);
  localparam logic signed [COEF_W-1:0] SQH = COEF_W'(SQH_I);

  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] stride, ang;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    phase_q <= '0;
    else if (adv_i) phase_q <= phase_q + 1'b1;
  end

  // angle in eighths of a turn
  always_comb begin
    unique case (mod_i)
      MOD_NONE:    stride = 3'd0;
      MOD_HALF:    stride = 3'd4;
      MOD_QUARTER: stride = 3'd2;
      default:     stride = 3'd1;
    endcase
  end

  assign ang = phase_q * stride;

  function automatic logic signed [COEF_W-1:0] cos8(input logic [PHASE_W-1:0] a);
    unique case (a)
      3'd0:       cos8 = ONE;
      3'd1, 3'd7: cos8 = SQH;
      3'd2, 3'd6: cos8 = '0;
      3'd3, 3'd5: cos8 = -SQH;
      default:    cos8 = -ONE;
    endcase
  endfunction

  always_comb begin
    cos_o  = cos8(ang);
    sin_o  = cos8(ang - 3'd2);
    real_o = (mod_i == MOD_NONE || mod_i == MOD_HALF) ? cos_o : sin_o;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/qm_lane.sv
module qm_lane #(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input  logic signed [DATA_W-1:0] x0_i,
  input  logic signed [COEF_W-1:0] c0_i,
  input  logic signed [DATA_W-1:0] x1_i,
  input  logic signed [COEF_W-1:0] c1_i,
  input  logic                     sub_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam int PW   = DATA_W + COEF_W;
  localparam int SW   = PW + 1;
  localparam int FRAC = COEF_W - 2;
  localparam logic signed [SW-1:0] MAX_S = {{(SW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [SW-1:0] MIN_S = {{(SW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [PW-1:0] p0, p1;
  logic signed [SW-1:0] sum, shr;

  assign p0 = x0_i * c0_i;
  assign p1 = x1_i * c1_i;

  always_comb begin
    sum = sub_i ? ({p0[PW-1], p0} - {p1[PW-1], p1})
                : ({p0[PW-1], p0} + {p1[PW-1], p1});
    shr = sum >>> FRAC;
    if (shr > MAX_S)      y_o = MAX_S[DATA_W-1:0];
    else if (shr < MIN_S) y_o = MIN_S[DATA_W-1:0];
    else                  y_o = shr[DATA_W-1:0];
  end
endmodule

// File: rtl/quad_mixer.sv
module quad_mixer
  import quad_mixer_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] i_data_i,
  input  logic [DATA_W-1:0] q_data_i,
  input  logic [1:0]        mod_sel_i,
  input  logic              cplx_en_i,
  input  logic              fmt_bin_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] dac_a_o,
  output logic [DATA_W-1:0] dac_b_o
);
  localparam int NCH = 2;

  logic [DATA_W-1:0]        raw [NCH];
  logic signed [DATA_W-1:0] smp [NCH];
  logic signed [DATA_W-1:0] mix [NCH];
  logic signed [COEF_W-1:0] cos_c, sin_c, real_c;
  logic [PHASE_W-1:0]       phase_q;
  mod_e                     mod_sel;

  assign raw[0]  = i_data_i;
  assign raw[1]  = q_data_i;
  assign mod_sel = mod_e'(mod_sel_i);

  qm_carrier #(.COEF_W(COEF_W)) u_carrier (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .adv_i   (valid_i),
    .mod_i   (mod_sel),
    .phase_o (phase_q),
    .cos_o   (cos_c),
    .sin_o   (sin_c),
    .real_o  (real_c)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic signed [DATA_W-1:0] x0, x1;
    logic signed [COEF_W-1:0] c0, c1;
    logic                     sub;

    qm_fmt #(.DATA_W(DATA_W)) u_fmt (
      .raw_i     (raw[ch]),
      .fmt_bin_i (fmt_bin_i),
      .smp_o     (smp[ch])
    );

    // A: I*cos - Q*sin ; B: Q*cos + I*sin ; real: own channel only
    always_comb begin
      x0  = smp[ch];
      x1  = smp[NCH-1-ch];
      c0  = cplx_en_i ? cos_c : real_c;
      c1  = cplx_en_i ? sin_c : '0;
      sub = (ch == 0);
    end

    qm_lane #(.DATA_W(DATA_W), .COEF_W(COEF_W)) u_lane (
      .x0_i  (x0),
      .c0_i  (c0),
      .x1_i  (x1),
      .c1_i  (c1),
      .sub_i (sub),
      .y_o   (mix[ch])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      dac_a_o <= '0;
      dac_b_o <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        dac_a_o <= mix[0];
        dac_b_o <= mix[1];
      end
    end
  end
endmodule

// File: rtl/qm_checker.sv
module qm_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [DATA_W-1:0] i_data_i,
  input logic [DATA_W-1:0] q_data_i,
  input logic [1:0]        mod_sel_i,
  input logic              cplx_en_i,
  input logic              fmt_bin_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] dac_a_o,
  input logic [DATA_W-1:0] dac_b_o,
  input logic [2:0]        phase_i
);
  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_VALID_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(dac_a_o) && $stable(dac_b_o))); // R2
  AST_PHASE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (phase_i == 3'($past(phase_i) + 3'd1))); // R2
  AST_PHASE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(phase_i)); // R2
  AST_NO_MOD_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mod_sel_i == 2'd0 && !fmt_bin_i)
      |=> (dac_a_o == $past(i_data_i) && dac_b_o == $past(q_data_i))); // R4
  AST_QUARTER_NULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && mod_sel_i == 2'd2 && !cplx_en_i && !phase_i[0])
      |=> (dac_a_o == '0 && dac_b_o == '0)); // R6
endmodule

bind quad_mixer qm_checker #(.DATA_W(DATA_W)) u_qm_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .i_data_i  (i_data_i),
  .q_data_i  (q_data_i),
  .mod_sel_i (mod_sel_i),
  .cplx_en_i (cplx_en_i),
  .fmt_bin_i (fmt_bin_i),
  .valid_o   (valid_o),
  .dac_a_o   (dac_a_o),
  .dac_b_o   (dac_b_o),
  .phase_i   (phase_q)
);

// File: tb/quad_mixer_bench.sv
`timescale 1ns/1ps
module quad_mixer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [15:0] i_data_i = '0;
  logic [15:0] q_data_i = '0;
  logic [1:0]  mod_sel_i = '0;
  logic        cplx_en_i = 1'b0;
  logic        fmt_bin_i = 1'b0;
  logic        valid_o;
  logic [15:0] dac_a_o, dac_b_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int ph = 0;
  bit exp_v = 0;
  int exp_a = 0, exp_b = 0;

  always #2.5 clk_i = ~clk_i;

  quad_mixer u_quad_mixer (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .i_data_i(i_data_i), .q_data_i(q_data_i), .mod_sel_i(mod_sel_i),
    .cplx_en_i(cplx_en_i), .fmt_bin_i(fmt_bin_i),
    .valid_o(valid_o), .dac_a_o(dac_a_o), .dac_b_o(dac_b_o)
  );

  localparam int S = 11585;
  localparam int U = 16384;
  int c8[8] = '{U, S, 0, -S, -U, -S, 0, S};
  int s8[8] = '{0, S, U, S, 0, -S, -U, -S};
  int c4[4] = '{U, 0, -U, 0};
  int s4[4] = '{0, U, 0, -U};

  function automatic int to_sgn(logic [15:0] r, bit bin);
    logic [15:0] t = r;
    if (bin) t[15] = ~t[15];
    return int'($signed(t));
  endfunction

  function automatic int sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return int'(v);
  endfunction

  task automatic carrier(int mode, int n, output int c, output int s, output int r);
    case (mode)
      0: begin c = U; s = 0; r = U; end
      1: begin c = (n % 2) ? -U : U; s = 0; r = c; end
      2: begin c = c4[n % 4]; s = s4[n % 4]; r = s; end
      default: begin c = c8[n % 8]; s = s8[n % 8]; r = s; end
    endcase
  endtask

  task automatic check(string tag, int a_exp, int b_exp, bit v_exp);
    int a_act = int'($signed(dac_a_o));
    int b_act = int'($signed(dac_b_o));
    checks++;
    if (valid_o !== v_exp || a_act != a_exp || b_act != b_exp) begin
      errors++;
      $display("FAIL %s: got v=%0b a=%0d b=%0d, expected v=%0b a=%0d b=%0d",
               tag, valid_o, a_act, b_act, v_exp, a_exp, b_exp);
    end
  endtask

  // drive at negedge, model at posedge, compare at following negedge
  task automatic step(string tag, bit v, logic [15:0] i, logic [15:0] q,
                      int mode, bit cx, bit bin);
    int c, s, r, iv, qv;
    longint sa, sb;
    valid_i = v; i_data_i = i; q_data_i = q;
    mod_sel_i = 2'(mode); cplx_en_i = cx; fmt_bin_i = bin;
    @(posedge clk_i);
    exp_v = v;
    if (v) begin
      carrier(mode, ph, c, s, r);
      iv = to_sgn(i, bin); qv = to_sgn(q, bin);
      if (cx) begin
        sa = longint'(iv) * c - longint'(qv) * s;
        sb = longint'(iv) * s + longint'(qv) * c;
      end else begin
        sa = longint'(iv) * r;
        sb = longint'(qv) * r;
      end
      exp_a = sat16(sa >>> 14);
      exp_b = sat16(sb >>> 14);
      ph = (ph + 1) % 8;
    end
    @(negedge clk_i);
    check(tag, exp_a, exp_b, exp_v);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; valid_i = 1'b0;
    repeat (2) @(negedge clk_i);
    ph = 0; exp_a = 0; exp_b = 0; exp_v = 0;
    check("R1", 0, 0, 1'b0);
    rst_ni = 1'b1;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    do_reset();
    // R4 pass-through, both modes
    step("R4", 1, 16'h1234, 16'hF00D, 0, 0, 0);
    step("R4", 1, 16'h8000, 16'h7FFF, 0, 1, 0);
    // R5 half rate, steps 2..5
    for (int k = 0; k < 4; k++) step("R5", 1, 16'd1000, 16'hFC18, 1, k[0], 0);
    // R9 negate of -32768 saturates (step 6 -> +, step 7 -> -)
    step("R9", 1, 16'h8000, 16'h8000, 1, 0, 0);
    step("R9", 1, 16'h8000, 16'h8000, 1, 0, 0);
    // R2 gaps hold outputs and phase
    step("R2", 0, 16'h1111, 16'h2222, 3, 0, 0);
    step("R2", 0, 16'h3333, 16'h4444, 2, 1, 0);
    // R6 quarter real over eight steps
    for (int k = 0; k < 8; k++) step("R6", 1, 16'd20000, 16'hB1E0, 2, 0, 0);
    // R7 eighth real with odd negatives (R10 floor)
    for (int k = 0; k < 8; k++) step("R7", 1, 16'd12345, 16'hFFFD, 3, 0, 0);
    // R8 complex eighth and quarter
    for (int k = 0; k < 8; k++) step("R8", 1, 16'd9000, 16'hE000, 3, 1, 0);
    for (int k = 0; k < 4; k++) step("R8", 1, 16'd7, 16'hFFF9, 2, 1, 0);
    // R9 full-scale complex eighth: B overranges
    for (int k = 0; k < 8; k++) step("R9", 1, 16'h7FFF, 16'h7FFF, 3, 1, 0);
    for (int k = 0; k < 8; k++) step("R9", 1, 16'h8000, 16'h7FFF, 3, 1, 0);
    // R3 straight binary
    step("R3", 1, 16'h8000, 16'h0000, 0, 0, 1);
    step("R3", 1, 16'hFFFF, 16'h7FFF, 1, 1, 1);
    // R1 mid-run reset returns phase to step 0
    step("R1", 1, 16'd500, 16'd500, 3, 0, 0);
    do_reset();
    step("R1", 1, 16'd20000, 16'd20000, 2, 0, 0);
    step("R1", 1, 16'd20000, 16'd20000, 2, 0, 0);
    // random mix
    for (int k = 0; k < 3000; k++) begin
      int m = $urandom_range(0, 3);
      bit cx = $urandom_range(0, 1);
      string tag;
      tag = cx ? "R8" : (m == 0 ? "R4" : m == 1 ? "R5" : m == 2 ? "R6" : "R7");
      step(tag, $urandom_range(0, 9) < 7, 16'($urandom), 16'($urandom),
           m, cx, $urandom_range(0, 3) == 0);
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule